// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block is the receive side of a stereo serial audio link in which the far end owns all timing. A bit clock runs the block. A frame clock marks which channel is being sent. One data line carries 24-bit words, most significant bit first. The block turns that stream into a parallel left word and a parallel right word. Each word comes with a one-cycle strobe in the bit-clock domain. Moving the words into any other clock domain is left to the logic that follows.

A format input picks between two framings. They differ in two ways:
- how many bit-clock edges pass between a frame-clock change and the first data bit;
- which frame-clock level stands for the left channel.

A half-frame may be longer than 24 bits, and the extra bits are dropped. A half-frame too short to hold a whole word yields nothing. The right strobe marks a complete stereo pair. It fires only when the left word of the same frame also arrived, so the consumer can take both words on that one strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and after it until the first word completes, both sample outputs are zero and both strobes are low.
- R2: With `fmt_left_just` = 1, the first data bit (the MSB) is the `ser_data` value sampled on the rising `bit_clk` edge at which a change of `frame_clk` is first seen. The next 23 edges carry the remaining bits, MSB first.
- R3: With `fmt_left_just` = 0, the MSB is the value sampled on the second rising edge after the frame-clock change. The first edge of the half-frame carries no data for the new word.
- R4: In the first mode (`fmt_left_just` = 1), `frame_clk` = 1 marks the left channel. In the second mode, `frame_clk` = 0 marks the left channel.
- R5: After the 24th bit of a half-frame, further `ser_data` bits are ignored until the next `frame_clk` change. A strobe reports each word with exactly the 24 captured bits.
- R6: If the frame clock changes before all 24 bits of a half-frame arrive, the partial word is discarded. No strobe is raised and the sample output keeps its previous value.
- R7: `left_strobe` is high for exactly one cycle, the cycle after the edge that sampled the left LSB. At that time `left_sample` shows the new word. `left_sample` does not change in any other cycle.
- R8: `right_strobe` rises in the cycle after the right LSB, and only if the left word of the same frame completed. At that point `left_sample` and `right_sample` together hold that frame's pair. A right word without its left partner updates `right_sample` silently. The two strobes are never high together.
- R9: After reset, no bits are captured until the first change of `frame_clk` is observed.
- R10: The format input takes effect at a frame-clock change. The half-frame already in progress keeps the format it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the link master; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk | input | 1 | Channel framing clock, sampled on `bit_clk` rising edges |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_left_just | input | 1 | 1 = left-justified framing, 0 = framing with a one-bit delay |
| left_sample | output | 24 | Last complete left word |
| left_strobe | output | 1 | One-cycle pulse when `left_sample` updates |
| right_sample | output | 24 | Last complete right word |
| right_strobe | output | 1 | One-cycle pulse when a complete left/right pair is present |

## Verification
Each strobe and its sample word are registered off the edge that samples the word's LSB, so they appear one bit-clock cycle after that edge. In the first mode that edge is 23 edges after the frame-clock change is seen; in the second mode it is 24 edges after. The bench model applies the same latency: it updates its expected outputs on the rising edge, and both model and design are compared at the following falling edge on every cycle. Directed checks then count strobes and compare the captured words only after an idle cycle has passed beyond each frame. In this way each late or early strobe shows up both as a per-cycle mismatch and as a wrong count.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

   typedef enum logic {
      FMT_DELAYED = 1'b0,
      FMT_LEFTJ   = 1'b1
   } sarx_fmt_e;

   // width of a half-frame position counter that saturates past the word
   function automatic int pos_width(input int word_w);
      return $clog2(word_w + 2) + 1;
   endfunction

endpackage

// File: rtl/sarx_frame_track.sv
module sarx_frame_track
   import sarx_pkg::*;
#(
   parameter int WORD_W = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lr_i,
   input  logic fmt_i,
   output logic start_o,
   output logic bit_en_o,
   output logic last_o,
   output logic is_left_o
);

   localparam int CW  = pos_width(WORD_W);
   localparam int SAT = WORD_W + 1;
   localparam logic [CW-1:0] SAT_C  = CW'(SAT);
   localparam logic [CW-1:0] WORD_C = CW'(WORD_W);
   localparam logic [CW-1:0] ONE_C  = CW'(1);

   logic            primed_q;
   logic            prev_lr_q;
   sarx_fmt_e       mode_q;
   logic            left_q;
   logic [CW-1:0]   cnt_q;

   sarx_fmt_e       mode_now;
   logic [CW-1:0]   pos;
   logic [CW-1:0]   lo;
   logic            left_now;

   always_comb begin
      start_o  = primed_q && (lr_i != prev_lr_q);
      mode_now = start_o ? sarx_fmt_e'(fmt_i) : mode_q;
      pos      = start_o ? '0 : cnt_q;
      left_now = start_o ? ((fmt_i == FMT_LEFTJ) ? lr_i : ~lr_i) : left_q;
      lo       = (mode_now == FMT_LEFTJ) ? '0 : ONE_C;
      bit_en_o = (pos >= lo) && (pos < lo + WORD_C);
      last_o   = bit_en_o && (pos == lo + WORD_C - ONE_C);
      is_left_o = left_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q  <= 1'b0;
         prev_lr_q <= 1'b0;
         mode_q    <= FMT_LEFTJ;
         left_q    <= 1'b0;
         cnt_q     <= SAT_C;
      end else begin
         primed_q  <= 1'b1;
         prev_lr_q <= lr_i;
         if (start_o) begin
            cnt_q  <= ONE_C;
            mode_q <= mode_now;
            left_q <= left_now;
         end else if (cnt_q != SAT_C) begin
            cnt_q <= cnt_q + ONE_C;
         end
      end
   end

   AST_IDLE_UNTIL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !primed_q |-> !bit_en_o); // R9
   AST_NO_BIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (!bit_en_o || start_o)); // R5
   AST_MODE_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !start_o |=> $stable(mode_q)); // R10

endmodule

// File: rtl/sarx_word_shift.sv
module sarx_word_shift #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sd_i,
   input  logic              bit_en_i,
   input  logic              last_i,
   output logic [WORD_W-1:0] word_o,
   output logic              done_o
);

   localparam int SH_W = WORD_W - 1;

   logic [SH_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (bit_en_i)
         sh_q <= {sh_q[SH_W-2:0], sd_i};
   end

   assign word_o = {sh_q, sd_i};
   assign done_o = bit_en_i && last_i;

   AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5

endmodule

// File: rtl/sarx_pair_out.sv
module sarx_pair_out #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              is_left_i,
   input  logic              done_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] left_o,
   output logic              left_vld_o,
   output logic [WORD_W-1:0] right_o,
   output logic              right_vld_o
);

   localparam int NCH = 2;

   logic [WORD_W-1:0] data_q [NCH];
   logic              have_left_q;
   logic              lv_q;
   logic              rv_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam logic IS_L = (c == 0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            data_q[c] <= '0;
         else if (done_i && (is_left_i == IS_L))
            data_q[c] <= word_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_left_q <= 1'b0;
         lv_q        <= 1'b0;
         rv_q        <= 1'b0;
      end else begin
         lv_q <= done_i && is_left_i;
         rv_q <= done_i && !is_left_i && have_left_q;
         if (done_i)
            have_left_q <= is_left_i;
         else if (start_i && is_left_i)
            have_left_q <= 1'b0;
      end
   end

   assign left_o      = data_q[0];
   assign right_o     = data_q[1];
   assign left_vld_o  = lv_q;
   assign right_vld_o = rv_q;

   AST_LEFT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      left_vld_o |=> !left_vld_o); // R7
   AST_LEFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !left_vld_o |-> $stable(left_o)); // R7
   AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(left_vld_o && right_vld_o)); // R8
   AST_RIGHT_NEEDS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      right_vld_o |-> $past(have_left_q)); // R8

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
   parameter int WORD_W = 24
) (
   input  logic              bit_clk,
   input  logic              rst_n,
   input  logic              frame_clk,
   input  logic              ser_data,
   input  logic              fmt_left_just,
   output logic [WORD_W-1:0] left_sample,
   output logic              left_strobe,
   output logic [WORD_W-1:0] right_sample,
   output logic              right_strobe
);

   if (WORD_W < 3) begin : g_bad_width
      $error("serial_audio_rx: WORD_W must be at least 3");
   end

   logic              start;
   logic              bit_en;
   logic              last;
   logic              is_left;
   logic              done;
   logic [WORD_W-1:0] word;

   sarx_frame_track #(.WORD_W(WORD_W)) u_track (
      .clk       (bit_clk),
      .rst_n     (rst_n),
      .lr_i      (frame_clk),
      .fmt_i     (fmt_left_just),
      .start_o   (start),
      .bit_en_o  (bit_en),
      .last_o    (last),
      .is_left_o (is_left)
   );

   sarx_word_shift #(.WORD_W(WORD_W)) u_shift (
      .clk      (bit_clk),
      .rst_n    (rst_n),
      .sd_i     (ser_data),
      .bit_en_i (bit_en),
      .last_i   (last),
      .word_o   (word),
      .done_o   (done)
   );

   sarx_pair_out #(.WORD_W(WORD_W)) u_out (
      .clk         (bit_clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .is_left_i   (is_left),
      .done_i      (done),
      .word_i      (word),
      .left_o      (left_sample),
      .left_vld_o  (left_strobe),
      .right_o     (right_sample),
      .right_vld_o (right_strobe)
   );

   AST_RESET_QUIET: assert property (@(posedge bit_clk)
      !rst_n |=> (!left_strobe && !right_strobe)); // R1

endmodule

// File: tb/serial_audio_rx_bench.sv
`timescale 1ns/1ps
module serial_audio_rx_bench;

   localparam int W = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_clk = 1'b0;
   logic          ser_data = 1'b0;
   logic          fmt_left_just = 1'b1;
   logic [W-1:0]  left_sample, right_sample;
   logic          left_strobe, right_strobe;

   always #10 clk = ~clk;

   serial_audio_rx #(.WORD_W(W)) u_serial_audio_rx (
      .bit_clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .ser_data(ser_data),
      .fmt_left_just(fmt_left_just), .left_sample(left_sample), .left_strobe(left_strobe),
      .right_sample(right_sample), .right_strobe(right_strobe));

   int nchk = 0, nfail = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic         m_primed, m_prev, m_mode, m_left, m_have;
   int           m_pos;
   logic         m_q[$];
   logic [W-1:0] e_l, e_r;
   logic         e_lv, e_rv;

   always @(posedge clk) begin
      e_lv = 0; e_rv = 0;
      if (!rst_n) begin
         m_primed = 0; m_prev = 0; m_mode = 1; m_left = 0; m_have = 0;
         m_pos = 100; m_q.delete(); e_l = '0; e_r = '0;
      end else if (!m_primed) begin
         m_primed = 1; m_prev = frame_clk;
      end else begin
         if (frame_clk != m_prev) begin
            m_pos = 0; m_mode = fmt_left_just;
            m_left = m_mode ? frame_clk : !frame_clk;
            if (m_left) m_have = 0;
            m_q.delete();
         end else if (m_pos < 100) m_pos++;
         m_prev = frame_clk;
         if (m_pos >= (m_mode ? 0 : 1) && m_pos < (m_mode ? 0 : 1) + W) begin
            m_q.push_back(ser_data);
            if (m_q.size() == W) begin
               logic [W-1:0] v;
               for (int i = 0; i < W; i++) v[W-1-i] = m_q[i];
               if (m_left) begin e_l = v; e_lv = 1; m_have = 1; end
               else begin e_r = v; e_rv = m_have; m_have = 0; end
            end
         end
      end
   end

   int cnt_l = 0, cnt_r = 0;
   logic [W-1:0] last_l, last_r;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(left_strobe == e_lv, "R7 left strobe", 32'(left_strobe), 32'(e_lv));
         chk(left_sample == e_l, "R7 left word", 32'(left_sample), 32'(e_l));
         chk(right_strobe == e_rv, "R8 right strobe", 32'(right_strobe), 32'(e_rv));
         chk(right_sample == e_r, "R8 right word", 32'(right_sample), 32'(e_r));
         if (left_strobe) begin cnt_l++; last_l = left_sample; end
         if (right_strobe) begin cnt_r++; last_r = right_sample; end
      end
   end

   // ---------------- stimulus ----------------
   task automatic half(input logic lv, input logic [W-1:0] w, input int len, input int off);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         frame_clk = lv;
         if (k - off >= 0 && k - off < W) ser_data = w[W-1-(k-off)];
         else ser_data = 1'($urandom % 2);
      end
   endtask

   task automatic settle();
      @(negedge clk); @(negedge clk);
   endtask

   task automatic frame_chk(input string req, input int dl, input int dr,
                            input logic [W-1:0] wl, input logic [W-1:0] wr,
                            input int bl, input int br);
      chk(cnt_l - bl == dl, {req, " left count"}, 32'(cnt_l - bl), 32'(dl));
      chk(cnt_r - br == dr, {req, " right count"}, 32'(cnt_r - br), 32'(dr));
      if (dl > 0) chk(last_l == wl, {req, " left word"}, 32'(last_l), 32'(wl));
      if (dr > 0) chk(last_r == wr, {req, " right word"}, 32'(last_r), 32'(wr));
   endtask

   initial begin
      int bl, br;
      repeat (3) @(negedge clk);
      chk(left_sample == 0 && right_sample == 0, "R1 samples in reset",
          32'(left_sample | right_sample), 0);
      chk(!left_strobe && !right_strobe, "R1 strobes in reset",
          32'({left_strobe, right_strobe}), 0);
      @(negedge clk); rst_n = 1;
      for (int i = 0; i < 10; i++) begin @(negedge clk); ser_data = 1'($urandom % 2); end
      chk(cnt_l == 0 && cnt_r == 0, "R9 no capture before edge", 32'(cnt_l + cnt_r), 0);
      chk(left_sample == 0, "R1 left idle after reset", 32'(left_sample), 0);

      // left-justified, long half-frames
      bl = cnt_l; br = cnt_r;
      half(1, 24'hA5C3F1, 32, 0); half(0, 24'h5E6F70, 32, 0); settle();
      frame_chk("R2 R4 R5 lj long", 1, 1, 24'hA5C3F1, 24'h5E6F70, bl, br);

      // left-justified, exact 24-bit half-frames
      bl = cnt_l; br = cnt_r;
      half(1, 24'h800001, 24, 0); half(0, 24'hFFFFFE, 24, 0); settle();
      frame_chk("R2 lj exact", 1, 1, 24'h800001, 24'hFFFFFE, bl, br);

      // switch to delayed format; high half is now the right channel
      fmt_left_just = 0;
      bl = cnt_l; br = cnt_r;
      half(1, 24'h123456, 32, 1); settle();
      frame_chk("R10 R8 lone right", 0, 0, 0, 0, bl, br);
      chk(right_sample == 24'h123456, "R8 lone right stored", 32'(right_sample), 32'h123456);

      bl = cnt_l; br = cnt_r;
      half(0, 24'hC0FFEE, 32, 1); half(1, 24'h0BADF0, 32, 1); settle();
      frame_chk("R3 R4 dly long", 1, 1, 24'hC0FFEE, 24'h0BADF0, bl, br);

      bl = cnt_l; br = cnt_r;
      half(0, 24'h13579B, 25, 1); half(1, 24'h2468AC, 25, 1); settle();
      frame_chk("R3 dly exact", 1, 1, 24'h13579B, 24'h2468AC, bl, br);

      // truncated left half: no left, no pair
      bl = cnt_l; br = cnt_r;
      half(0, 24'hDEAD00, 20, 1); half(1, 24'h00BEEF, 32, 1); settle();
      frame_chk("R6 R8 short left", 0, 0, 0, 0, bl, br);
      chk(left_sample == 24'h13579B, "R6 left kept", 32'(left_sample), 32'h13579B);

      bl = cnt_l; br = cnt_r;
      half(0, 24'h6A6A6A, 28, 1); half(1, 24'h959595, 28, 1);
      for (int i = 0; i < 12; i++) begin @(negedge clk); ser_data = 1'($urandom % 2); end
      frame_chk("R5 R3 trailing junk", 1, 1, 24'h6A6A6A, 24'h959595, bl, br);

      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done_flag) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule